// File: doc/BRIEF.md
# Recovered-Clock Frequency Lock Monitor

This block decides whether a clock recovered from an incoming serial stream runs at the rate its local reference predicts. A divided copy of the recovered clock is carried into the reference domain as a toggle and counted over a fixed window of reference cycles. At the end of each window the count is compared against an expected value, with a tolerance band around it. The rate input tells the block whether the reference runs at the character rate or at half of it. At half rate the recovered clock must run twice as fast as the reference, so the expected count doubles.

The outcome drives a small lock state machine with hysteresis. One failing window drops lock at once. Lock returns only after two in-range windows in a row. While unlocked, the block raises a fault flag and a select that tells the clock-recovery loop to follow the reference instead of the data. When lock is lost and swapping is enabled, the block toggles a select between two redundant serial inputs. It then ignores the next window, which may have been measured across the switch, so the new stream gets time to be acquired.

Top module: `freq_lock_monitor`

## Requirements
- R1: While reset is applied and directly after it, `line_fault` = 1, `track_ref` = 1 and `in_sel` = 0.
- R2: With `half_rate` = 0 and a recovered clock at the reference frequency (within 0.2 %), the block becomes locked: `line_fault` and `track_ref` go to 0.
- R3: With `half_rate` = 1, lock requires a recovered clock at twice the reference frequency. A recovered clock at the reference frequency counts as out of range.
- R4: A single in-range window after an unlocked state does not clear `line_fault`. Two consecutive in-range windows are needed.
- R5: One window whose count lies outside the expected value ± tolerance sets `line_fault` and `track_ref` again, counted from the window's end.
- R6: An out-of-range window after one in-range window cancels the progress toward lock. Two fresh in-range windows are then needed.
- R7: `in_sel` inverts exactly once when lock is lost while `swap_en` = 1. Out-of-range windows while already unlocked never change it.
- R8: With `swap_en` = 0 at the window end where lock is lost, `in_sel` keeps its value.
- R9: The window that follows an `in_sel` toggle is discarded whatever its count, so `line_fault` stays 1 for at least three window ends after a swap.
- R10: `track_ref` always equals `line_fault`.
- R11: A recovered clock that stops completely yields an out-of-range window and sets `line_fault`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Local reference clock; all outputs are in this domain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| clk_rec | input | 1 | Clock recovered from the serial stream |
| half_rate | input | 1 | 1: reference runs at half the character rate (expected count doubled) |
| swap_en | input | 1 | 1: toggle `in_sel` when lock is lost |
| line_fault | output | 1 | 1: recovered clock not judged valid |
| track_ref | output | 1 | 1: recovery loop should follow the reference instead of the data |
| in_sel | output | 1 | Selects one of two redundant serial inputs |

## Verification
Two events can resolve at the same window end: the loss of lock and the input swap with its discard window. The two also interact in the very next window, where a hold release and an in-range count land together. The bench makes a locked stream fail with swapping enabled, then supplies a clean stream in the following window. It expects `line_fault` to stay high through that window, and it expects `in_sel` to toggle only once. It repeats the case with a stopped recovered clock. It also provokes an out-of-range window while already unlocked with swapping enabled, and it judges that case by `in_sel` staying put.

// File: rtl/flm_pkg.sv
package flm_pkg;
  typedef enum logic [1:0] {
    LK_HUNT = 2'd0,
    LK_PEND = 2'd1,
    LK_HELD = 2'd2
  } lock_state_t;
endpackage

// File: rtl/flm_rst_sync.sv
module flm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign srst_n = sh_q[1];
endmodule

// File: rtl/flm_rec_tap.sv
// Recovered-clock domain: divides by 2**PRE_LOG2 and toggles a level per period.
module flm_rec_tap #(
  parameter int PRE_LOG2 = 2
) (
  input  logic clk_rec,
  input  logic rst_n,
  output logic tap
);
  logic [PRE_LOG2-1:0] div_q, div_d;
  logic                tap_q, tap_d;

  always_comb begin
    div_d = div_q + PRE_LOG2'(1);
    tap_d = tap_q ^ (div_q == '1);
  end

  always_ff @(posedge clk_rec or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tap_q <= 1'b0;
    end else begin
      div_q <= div_d;
      tap_q <= tap_d;
    end
  end

  assign tap = tap_q;
endmodule

// File: rtl/flm_window.sv
// Reference domain: synchronises the tap, counts its edges over 2**WIN_LOG2 cycles.
module flm_window #(
  parameter int WIN_LOG2 = 14,
  parameter int CNT_W    = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tap_async,
  output logic             win_done,
  output logic [CNT_W-1:0] win_count
);
  logic [2:0]          tap_sh_q;
  logic [WIN_LOG2-1:0] tick_q, tick_d;
  logic [CNT_W-1:0]    acc_q, acc_d, acc_inc, cnt_q, cnt_d;
  logic                done_q, done_d, tap_edge, win_last;

  always_comb begin
    tap_edge = tap_sh_q[2] ^ tap_sh_q[1];
    win_last = (tick_q == '1);
    tick_d   = tick_q + WIN_LOG2'(1);
    acc_inc  = (acc_q == '1) ? acc_q : acc_q + CNT_W'(tap_edge);
    acc_d    = win_last ? '0 : acc_inc;
    cnt_d    = win_last ? acc_inc : cnt_q;
    done_d   = win_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_sh_q <= '0;
      tick_q   <= '0;
      acc_q    <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      tap_sh_q <= {tap_sh_q[1:0], tap_async};
      tick_q   <= tick_d;
      acc_q    <= acc_d;
      cnt_q    <= cnt_d;
      done_q   <= done_d;
    end
  end

  assign win_done  = done_q;
  assign win_count = cnt_q;
endmodule

// File: rtl/flm_lock_ctrl.sv
// Range decision, lock hysteresis, redundant input swap and discard window.
module flm_lock_ctrl
  import flm_pkg::*;
#(
  parameter int CNT_W    = 15,
  parameter int EXP_FULL = 4096,
  parameter int EXP_HALF = 8192,
  parameter int TOL_FULL = 8,
  parameter int TOL_HALF = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_done,
  input  logic [CNT_W-1:0] win_count,
  input  logic             half_rate,
  input  logic             swap_en,
  output logic             locked,
  output logic             in_sel
);
  localparam logic [CNT_W-1:0] EXP_F = CNT_W'(EXP_FULL);
  localparam logic [CNT_W-1:0] EXP_H = CNT_W'(EXP_HALF);
  localparam logic [CNT_W-1:0] TOL_F = CNT_W'(TOL_FULL);
  localparam logic [CNT_W-1:0] TOL_H = CNT_W'(TOL_HALF);

  lock_state_t      st_q, st_d;
  logic             sel_q, sel_d, hold_q, hold_d, in_range;
  logic [CNT_W-1:0] exp_sel, tol_sel, diff;

  always_comb begin
    exp_sel  = half_rate ? EXP_H : EXP_F;
    tol_sel  = half_rate ? TOL_H : TOL_F;
    diff     = (win_count >= exp_sel) ? (win_count - exp_sel) : (exp_sel - win_count);
    in_range = (diff <= tol_sel);
  end

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    hold_d = hold_q;
    if (win_done) begin
      if (hold_q) begin
        hold_d = 1'b0;
      end else begin
        unique case (st_q)
          LK_HUNT: if (in_range) st_d = LK_PEND;
          LK_PEND: st_d = in_range ? LK_HELD : LK_HUNT;
          LK_HELD: if (!in_range) begin
            st_d = LK_HUNT;
            if (swap_en) begin
              sel_d  = ~sel_q;
              hold_d = 1'b1;
            end
          end
          default: st_d = LK_HUNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LK_HUNT;
      sel_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      hold_q <= hold_d;
    end
  end

  assign locked = (st_q == LK_HELD);
  assign in_sel = sel_q;
endmodule

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor #(
  parameter int WIN_LOG2 = 14,
  parameter int PRE_LOG2 = 2,
  parameter int TOL_PPM  = 1500,
  parameter int GUARD    = 2
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic clk_rec,
  input  logic half_rate,
  input  logic swap_en,
  output logic line_fault,
  output logic track_ref,
  output logic in_sel
);
  localparam int CNT_W    = WIN_LOG2 - PRE_LOG2 + 3;
  localparam int EXP_FULL = 2 ** (WIN_LOG2 - PRE_LOG2);
  localparam int EXP_HALF = 2 * EXP_FULL;
  localparam int TOL_FULL = (EXP_FULL / 1000) * TOL_PPM / 1000 + GUARD;
  localparam int TOL_HALF = (EXP_HALF / 1000) * TOL_PPM / 1000 + GUARD;

  logic             ref_rst_n, rec_rst_n, tap, win_pulse, locked;
  logic [CNT_W-1:0] win_count;

  flm_rst_sync u_ref_rst (.clk(clk_ref), .arst_n(rst_n), .srst_n(ref_rst_n));
  flm_rst_sync u_rec_rst (.clk(clk_rec), .arst_n(rst_n), .srst_n(rec_rst_n));

  flm_rec_tap #(.PRE_LOG2(PRE_LOG2)) u_tap (
    .clk_rec(clk_rec), .rst_n(rec_rst_n), .tap(tap)
  );

  flm_window #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) u_win (
    .clk(clk_ref), .rst_n(ref_rst_n), .tap_async(tap),
    .win_done(win_pulse), .win_count(win_count)
  );

  flm_lock_ctrl #(
    .CNT_W(CNT_W), .EXP_FULL(EXP_FULL), .EXP_HALF(EXP_HALF),
    .TOL_FULL(TOL_FULL), .TOL_HALF(TOL_HALF)
  ) u_ctrl (
    .clk(clk_ref), .rst_n(ref_rst_n), .win_done(win_pulse), .win_count(win_count),
    .half_rate(half_rate), .swap_en(swap_en), .locked(locked), .in_sel(in_sel)
  );

  assign line_fault = ~locked;
  assign track_ref  = ~locked;
endmodule

// File: rtl/freq_lock_monitor_checks.sv
module freq_lock_monitor_checks (
  input logic clk,
  input logic rst_n,
  input logic win_done,
  input logic swap_en,
  input logic line_fault,
  input logic in_sel
);
  logic [1:0] wins_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         wins_q <= 2'd0;
    else if (!line_fault)               wins_q <= 2'd0;
    else if (win_done && wins_q != 2'd3) wins_q <= wins_q + 2'd1;
  end

  assert_lock_at_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_fault) |-> $past(win_done));

  assert_two_windows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_fault) |-> (wins_q >= 2'd2));

  assert_fault_at_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_fault) |-> $past(win_done));

  assert_swap_on_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sel != $past(in_sel)) |-> $rose(line_fault));

  assert_swap_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sel != $past(in_sel)) |-> $past(swap_en));
endmodule

bind freq_lock_monitor freq_lock_monitor_checks u_checks (
  .clk(clk_ref), .rst_n(rst_n), .win_done(win_pulse),
  .swap_en(swap_en), .line_fault(line_fault), .in_sel(in_sel)
);

// File: tb/freq_lock_monitor_test.sv
`timescale 1ps/1ps
module freq_lock_monitor_test;
  logic clk_ref, clk_rec, rst_n, half_rate, swap_en;
  logic line_fault, track_ref, in_sel;
  int   total, bad;

  typedef struct { logic fault; logic sel; string tag; } exp_t;
  exp_t exp_q[$];

  bit rec_run;
  int rec_half;
  // model of the previous window's settings and of the lock state
  bit p_run, p_hr, p_sw;
  int p_per;
  int m_st;
  bit m_sel, m_hold;

  freq_lock_monitor #(.WIN_LOG2(10)) uut (
    .clk_ref(clk_ref), .rst_n(rst_n), .clk_rec(clk_rec), .half_rate(half_rate),
    .swap_en(swap_en), .line_fault(line_fault), .track_ref(track_ref), .in_sel(in_sel)
  );

  initial begin clk_ref = 1'b0; forever #2000 clk_ref = ~clk_ref; end

  initial begin
    clk_rec = 1'b0;
    forever begin
      if (rec_run) #(rec_half) clk_rec = ~clk_rec;
      else #1000;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit win_good(input bit run, input int per, input bit hr);
    int nom, d;
    nom = hr ? 2000 : 4000;
    d   = (per > nom) ? per - nom : nom - per;
    return run && (d * 1000 <= nom * 2);
  endfunction

  // driver: at a window boundary, predict the outcome of the window just
  // closed, queue it, then apply the next window's stimulus
  task automatic step(input bit run, input int per, input bit hr, input bit sw, input string tag);
    bit g;
    exp_t e;
    repeat (1016) @(negedge clk_ref);
    g = win_good(p_run, p_per, p_hr);
    if (m_hold) m_hold = 1'b0;
    else case (m_st)
      0: if (g) m_st = 1;
      1: m_st = g ? 2 : 0;
      default: if (!g) begin
        m_st = 0;
        if (p_sw) begin m_sel = ~m_sel; m_hold = 1'b1; end
      end
    endcase
    e.fault = (m_st != 2);
    e.sel   = m_sel;
    e.tag   = tag;
    exp_q.push_back(e);
    rec_run  = run;
    rec_half = per / 2;
    p_run = run; p_per = per;
    repeat (8) @(negedge clk_ref);
    half_rate = hr; swap_en = sw;
    p_hr = hr; p_sw = sw;
  endtask

  // monitor: mid-window sampling, far from any window boundary
  initial begin
    exp_t e;
    @(posedge rst_n);
    repeat (1536) @(negedge clk_ref);
    forever begin
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(e.tag, line_fault, e.fault);
        check("R10", track_ref, line_fault);
        check(e.tag, in_sel, e.sel);
      end
      repeat (1024) @(negedge clk_ref);
    end
  end

  initial begin
    repeat (60000) @(posedge clk_ref);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; half_rate = 1'b0; swap_en = 1'b0;
    rec_run = 1'b0; rec_half = 2001;
    p_run = 1'b0; p_per = 4002; p_hr = 1'b0; p_sw = 1'b0;
    m_st = 0; m_sel = 1'b0; m_hold = 1'b0;
    repeat (5) @(negedge clk_ref);
    check("R1", line_fault, 1'b1);
    check("R1", track_ref, 1'b1);
    check("R1", in_sel, 1'b0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk_ref);
    step(1, 4002, 0, 0, "R11");  // window 0: clock stopped
    step(1, 4002, 0, 0, "R4");   // one good window only
    step(1, 4002, 0, 0, "R2");   // locked
    step(1, 4400, 0, 0, "R2");
    step(1, 4002, 0, 0, "R5");   // slow window drops lock, swap off (R8)
    step(1, 3600, 0, 0, "R4");
    step(1, 4002, 0, 0, "R6");   // fast window cancels pending
    step(1, 4002, 0, 0, "R6");
    step(1, 2002, 1, 0, "R2");
    step(1, 4002, 1, 1, "R3");   // half-rate good
    step(1, 2002, 1, 1, "R7");   // half-rate at ref freq is bad: swap
    step(1, 2002, 1, 1, "R9");   // discarded window
    step(1, 2002, 1, 1, "R3");
    step(0, 2002, 1, 1, "R3");
    step(1, 4002, 0, 1, "R11");  // stopped clock: loss and swap back
    step(1, 4002, 0, 1, "R9");
    step(1, 4002, 0, 1, "R4");
    step(1, 2200, 0, 0, "R2");
    step(1, 4400, 0, 1, "R8");   // lock lost, swap disabled
    step(1, 4002, 0, 1, "R7");   // bad while unlocked: no toggle
    step(1, 4002, 0, 1, "R4");
    repeat (700) @(negedge clk_ref);
    check("R2", exp_q.size() == 0, 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule